// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the clock and data lines driven by a PS/2 keyboard, brings both into the system clock domain, and turns each 11-bit device-to-host frame into one received byte. The keyboard clock is slow, roughly 10 to 15 kHz, against a system clock of tens of MHz. Each line passes through a multi-flop synchronizer. A glitch filter then accepts a change of the keyboard clock only after the synchronized level has held for a set number of system cycles. On every accepted falling edge the data line is sampled and a bit counter advances.

A frame is one start bit, eight data bits with the least significant bit first, one parity bit and one stop bit. The receiver checks all three framing bits instead of throwing them away. A clean frame raises a one-cycle valid strobe, and the byte appears with its bits in their natural order. A frame with bad parity, a bad start bit or a bad stop bit raises a one-cycle error strobe instead, and no valid strobe. A missed or extra keyboard clock edge would otherwise throw off every frame after it. To prevent this, an idle timeout inside a frame clears the bit counter and drops the partial frame, so the next frame starts aligned.

The keyboard cannot be paused, so the output has no back-pressure. The byte is qualified by the valid strobe for exactly one cycle, and the consumer must take it in that cycle. The byte output holds its last good value until the next good frame.

Top module: `ps2_kbd_rx`

## Requirements
- R1: After reset, rx_valid_o, parity_err_o and frame_err_o are 0, and rx_byte_o is 0x00.
- R2: A frame with start bit 0, odd parity and stop bit 1 produces one rx_valid_o pulse. The first data bit received appears at rx_byte_o bit 0 and the eighth at bit 7.
- R3: rx_valid_o is high for exactly one cycle per good frame, and is never high in the same cycle as parity_err_o or frame_err_o.
- R4: Parity is odd over the eight data bits plus the parity bit. A frame whose count of ones over those nine bits is even raises parity_err_o for one cycle, and rx_valid_o stays low for that frame.
- R5: A frame whose start bit is 1 raises frame_err_o and produces no rx_valid_o pulse.
- R6: A frame whose stop bit is 0 raises frame_err_o and produces no rx_valid_o pulse.
- R7: If no accepted clock fall occurs for TIMEOUT_CYCLES system cycles while a frame is partly received, the partial frame is dropped with no strobe. The next complete frame is then received correctly.
- R8: A low pulse on ps2_clk_i shorter than FILTER_CYCLES system cycles is not counted as a clock edge. A frame containing such a glitch still decodes correctly.
- R9: parity_err_o and frame_err_o are each high for exactly one cycle per failing frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | Keyboard clock line, asynchronous |
| ps2_dat_i | input | 1 | Keyboard data line, asynchronous |
| rx_valid_o | output | 1 | One-cycle strobe: a good frame was received |
| rx_byte_o | output | 8 | Received byte, LSB first on the wire; held until the next good frame |
| parity_err_o | output | 1 | One-cycle strobe: parity check failed |
| frame_err_o | output | 1 | One-cycle strobe: start or stop bit wrong |

## Verification
The bench builds the receiver with FILTER_CYCLES = 4 and TIMEOUT_CYCLES = 200. It drives the keyboard clock with a half-period of 40 system cycles, which scales the line rate up so that many frames fit in a short run. At these values, a 2-cycle glitch falls clearly below the filter threshold, while the 80-cycle bit period stays well inside the timeout. An abandoned partial frame followed by a 400-cycle gap therefore exercises the realignment path in a few hundred cycles.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
  localparam int unsigned PS2_DATA_BITS = 8;
  localparam int unsigned PS2_PAR_IDX   = PS2_DATA_BITS + 1;
  localparam int unsigned PS2_STOP_IDX  = PS2_DATA_BITS + 2;

  typedef logic [3:0]               bit_idx_t;
  typedef logic [PS2_DATA_BITS-1:0] ps2_byte_t;
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int unsigned STAGES   = 2,
  parameter bit          RST_LVL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_LVL;
          else        chain[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_LVL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/ps2_glitch_filter.sv
module ps2_glitch_filter #(
  parameter int unsigned FILTER_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic lvl_o,
  output logic fall_o
);
  localparam int unsigned CW = (FILTER_CYCLES > 1) ? $clog2(FILTER_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FILTER_CYCLES - 1);

  logic [CW-1:0] run_cnt;
  logic          commit;

  assign commit = (lvl_i != lvl_o) && (run_cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_o   <= 1'b1;
      run_cnt <= '0;
      fall_o  <= 1'b0;
    end else begin
      fall_o <= commit && lvl_o && !lvl_i;
      if (lvl_i == lvl_o) begin
        run_cnt <= '0;
      end else if (commit) begin
        lvl_o   <= lvl_i;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  AST_LEVEL_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_o != $past(lvl_o)) |-> ($past(lvl_i) == lvl_o)); // R8
  AST_FALL_FOLLOWS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> !lvl_o); // R8
endmodule

// File: rtl/ps2_frame_shifter.sv
module ps2_frame_shifter
  import ps2rx_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 5000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fall_i,
  input  logic      dat_i,
  output logic      valid_o,
  output ps2_byte_t byte_o,
  output logic      perr_o,
  output logic      ferr_o
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] IDLE_LAST = TW'(TIMEOUT_CYCLES - 1);
  localparam bit_idx_t PAR_IDX  = bit_idx_t'(PS2_PAR_IDX);
  localparam bit_idx_t STOP_IDX = bit_idx_t'(PS2_STOP_IDX);

  bit_idx_t      bit_idx;
  ps2_byte_t     shreg;
  logic          start_bad;
  logic          par_acc;
  logic [TW-1:0] idle_cnt;
  logic          stop_ok, par_ok;

  assign stop_ok = dat_i;
  assign par_ok  = par_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx   <= '0;
      shreg     <= '0;
      start_bad <= 1'b0;
      par_acc   <= 1'b0;
      idle_cnt  <= '0;
      valid_o   <= 1'b0;
      byte_o    <= '0;
      perr_o    <= 1'b0;
      ferr_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      if (fall_i) begin
        idle_cnt <= '0;
        if (bit_idx == '0) begin
          start_bad <= dat_i;
          par_acc   <= 1'b0;
          bit_idx   <= bit_idx + 4'd1;
        end else if (bit_idx < PAR_IDX) begin
          shreg   <= {dat_i, shreg[PS2_DATA_BITS-1:1]};
          par_acc <= par_acc ^ dat_i;
          bit_idx <= bit_idx + 4'd1;
        end else if (bit_idx == PAR_IDX) begin
          par_acc <= par_acc ^ dat_i;
          bit_idx <= bit_idx + 4'd1;
        end else begin
          bit_idx <= '0;
          if (par_ok && stop_ok && !start_bad) begin
            valid_o <= 1'b1;
            byte_o  <= shreg;
          end else begin
            perr_o <= !par_ok;
            ferr_o <= start_bad || !stop_ok;
          end
        end
      end else if (bit_idx == '0) begin
        idle_cnt <= '0;
      end else if (idle_cnt == IDLE_LAST) begin
        bit_idx  <= '0;
        idle_cnt <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  AST_VALID_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($past(bit_idx) == STOP_IDX)); // R2
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R3
  AST_VALID_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && (perr_o || ferr_o))); // R3
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_o || ferr_o) |=> !(perr_o || ferr_o)); // R9
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= STOP_IDX); // R7
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(byte_o)); // R2
endmodule

// File: rtl/ps2_kbd_rx.sv
module ps2_kbd_rx
  import ps2rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned FILTER_CYCLES  = 8,
  parameter int unsigned TIMEOUT_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  output logic       parity_err_o,
  output logic       frame_err_o
);
  logic clk_s, dat_s, clk_f, fall;

  ps2_line_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) i_sync_clk (
    .clk(clk), .rst_n(rst_n), .async_i(ps2_clk_i), .sync_o(clk_s));

  ps2_line_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) i_sync_dat (
    .clk(clk), .rst_n(rst_n), .async_i(ps2_dat_i), .sync_o(dat_s));

  ps2_glitch_filter #(.FILTER_CYCLES(FILTER_CYCLES)) i_filter (
    .clk(clk), .rst_n(rst_n), .lvl_i(clk_s), .lvl_o(clk_f), .fall_o(fall));

  ps2_frame_shifter #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) i_shifter (
    .clk(clk), .rst_n(rst_n), .fall_i(fall), .dat_i(dat_s),
    .valid_o(rx_valid_o), .byte_o(rx_byte_o),
    .perr_o(parity_err_o), .ferr_o(frame_err_o));

  AST_FALL_ON_LOW_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> !clk_f); // R8
endmodule

// File: tb/test_ps2_kbd_rx.sv
module test_ps2_kbd_rx;
  localparam int HALF = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ps2_clk = 1'b1;
  logic ps2_dat = 1'b1;
  logic rx_valid, perr, ferr;
  logic [7:0] rx_byte;

  int n_checks = 0;
  int n_fail = 0;
  int n_valid = 0, n_perr = 0, n_ferr = 0, n_wide = 0, n_clash = 0;
  logic [7:0] last_byte = 8'h00;
  bit prev_v = 0, prev_e = 0, done = 0;

  always #10 clk = ~clk;

  ps2_kbd_rx #(.SYNC_STAGES(2), .FILTER_CYCLES(4), .TIMEOUT_CYCLES(200)) i_ps2_kbd_rx (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
    .rx_valid_o(rx_valid), .rx_byte_o(rx_byte),
    .parity_err_o(perr), .frame_err_o(ferr));

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin n_valid++; last_byte = rx_byte; end
      if (perr) n_perr++;
      if (ferr) n_ferr++;
      if (rx_valid && prev_v) n_wide++;
      if ((perr || ferr) && prev_e) n_wide++;
      if (rx_valid && (perr || ferr)) n_clash++;
      prev_v = rx_valid;
      prev_e = perr || ferr;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit start_b, input bit flip_par,
                            input bit stop_b, input int nbits, input bit glitch);
    logic [10:0] b;
    b[0] = start_b;
    b[8:1] = d;
    b[9] = (~^d) ^ flip_par;
    b[10] = stop_b;
    for (int i = 0; i < nbits; i++) begin
      ps2_dat = b[i];
      cyc(HALF);
      ps2_clk = 1'b0;
      cyc(HALF);
      ps2_clk = 1'b1;
      if (glitch && i == 3) begin
        cyc(10);
        ps2_clk = 1'b0;
        cyc(2);
        ps2_clk = 1'b1;
      end
    end
    ps2_dat = 1'b1;
    cyc(300);
  endtask

  task automatic t_reset;
    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    @(negedge clk);
    chk("R1 valid after reset", int'(rx_valid), 0);
    chk("R1 parity_err after reset", int'(perr), 0);
    chk("R1 frame_err after reset", int'(ferr), 0);
    chk("R1 byte after reset", int'(rx_byte), 0);
    #2;
  endtask

  task automatic t_good(input logic [7:0] d);
    int v0 = n_valid, p0 = n_perr, f0 = n_ferr;
    send_frame(d, 1'b0, 1'b0, 1'b1, 11, 1'b0);
    chk("R2 one valid per good frame", n_valid - v0, 1);
    chk("R2 byte LSB first", int'(last_byte), int'(d));
    chk("R2 no error on good frame", (n_perr - p0) + (n_ferr - f0), 0);
  endtask

  task automatic t_parity;
    int v0 = n_valid, p0 = n_perr, f0 = n_ferr;
    send_frame(8'h3C, 1'b0, 1'b1, 1'b1, 11, 1'b0);
    chk("R4 parity_err pulse", n_perr - p0, 1);
    chk("R4 no valid on parity fault", n_valid - v0, 0);
    chk("R4 no frame_err on parity fault", n_ferr - f0, 0);
  endtask

  task automatic t_start;
    int v0 = n_valid, f0 = n_ferr;
    send_frame(8'h5A, 1'b1, 1'b0, 1'b1, 11, 1'b0);
    chk("R5 frame_err on bad start", n_ferr - f0, 1);
    chk("R5 no valid on bad start", n_valid - v0, 0);
  endtask

  task automatic t_stop;
    int v0 = n_valid, f0 = n_ferr;
    send_frame(8'hC3, 1'b0, 1'b0, 1'b0, 11, 1'b0);
    chk("R6 frame_err on bad stop", n_ferr - f0, 1);
    chk("R6 no valid on bad stop", n_valid - v0, 0);
  endtask

  task automatic t_timeout;
    int v0 = n_valid, p0 = n_perr, f0 = n_ferr;
    send_frame(8'hFF, 1'b0, 1'b0, 1'b1, 4, 1'b0);
    cyc(100);
    chk("R7 partial frame gives no strobe",
        (n_valid - v0) + (n_perr - p0) + (n_ferr - f0), 0);
    send_frame(8'hA5, 1'b0, 1'b0, 1'b1, 11, 1'b0);
    chk("R7 realigned frame valid", n_valid - v0, 1);
    chk("R7 realigned byte", int'(last_byte), 8'hA5);
    chk("R7 no error after realign", (n_perr - p0) + (n_ferr - f0), 0);
  endtask

  task automatic t_glitch;
    int v0 = n_valid, p0 = n_perr, f0 = n_ferr;
    send_frame(8'h96, 1'b0, 1'b0, 1'b1, 11, 1'b1);
    chk("R8 glitched frame valid", n_valid - v0, 1);
    chk("R8 glitched frame byte", int'(last_byte), 8'h96);
    chk("R8 glitch causes no error", (n_perr - p0) + (n_ferr - f0), 0);
  endtask

  task automatic t_widths;
    chk("R3 R9 strobes one cycle wide", n_wide, 0);
    chk("R3 valid never with error", n_clash, 0);
    chk("R9 error pulses total", n_perr + n_ferr, 3);
  endtask

  initial begin
    t_reset;
    t_good(8'h01);
    t_good(8'h80);
    t_good(8'hA5);
    t_good(8'h00);
    t_good(8'h7E);
    t_parity;
    t_start;
    t_stop;
    t_timeout;
    t_glitch;
    t_widths;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule